// File: doc/BRIEF.md
# Link Power State Controller

This block sequences the power state of a four-lane video link redriver. It picks one of three states: power down, standby (waiting on squelch), and normal operation. From that state it drives the enables for the lane receivers, the output transmitters, the side-channel (DDC) buffer and the hot-plug output.

Its inputs are:
- an enable pin and the hot-plug level;
- three control bits that software holds: force power down, inhibit hot-plug power down, and bypass standby;
- a mode bit that selects the legacy TMDS or the FRL lane arrangement;
- one signal-detect level per candidate monitored lane;
- a one-cycle strobe raised when a link-training pattern has been seen on the side channel.

Hot-plug, signal-detect and idle conditions are each qualified by a saturating cycle counter, and each counter has its own length parameter. Analog squelch, equalization, register decode and side-channel snooping all sit outside the block.

All outputs, including the state code, are registered. They change on the clock edge that samples the condition causing the change.

A debounce of N cycles works as follows:
- It completes once its condition has been sampled on N consecutive edges.
- The state changes on the edge after that.
- The count restarts whenever the condition drops.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `pwr_en` is low, the block goes to power down on the next edge. `link_state`, `rx_lane_en`, `tx_drive_en`, `ddc_en`, `hp_out_oe` and `hp_out` are then all 0, so the hot-plug output and the side channel float.
- R2: With `pwr_en` high, power down is entered on the next edge if `force_pd` is set. It is also entered one edge after `hp_det` has been sampled low on HP_LOSS_CYC consecutive edges, provided `hp_pd_inhibit` is clear. In this power down, `ddc_en`=1, `hp_out_oe`=1 and `hp_out`=0, and all receivers and transmitters are off.
- R3: While `hp_pd_inhibit` is set, a low `hp_det` of any length never causes power down. Outside power down, `hp_out` is then driven 1.
- R4: Power down is left one edge after `hp_det` has been sampled high on HP_GOOD_CYC consecutive edges with `pwr_en` high. If `hp_pd_inhibit` is set, it is left on the first edge where `pwr_en` is high and `force_pd` is clear. The block leaves to standby, or to normal when `stby_bypass` is set.
- R5: In standby, exactly one receiver is enabled and the transmitters are off. Lane bit NUM_LANES-1 is the clock lane and is used when `frl_mode`=0. Bit 2 is data lane 2 and is used when `frl_mode`=1. The detect input of the lane not being monitored has no effect.
- R6: In standby, once the monitored detect input has been sampled high on SQ_VALID_CYC consecutive edges, the block moves to normal on the next edge. A shorter pulse leaves it in standby. In normal, every receiver bit and `tx_drive_en` are 1.
- R7: In normal, once the monitored detect input has been sampled low on SQ_IDLE_CYC consecutive edges, the block returns to standby on the next edge.
- R8: A `train_seen` strobe sampled in standby moves the block to normal on the next edge, with no signal-detect debounce. The idle count then starts afresh from the normal-state entry.
- R9: While `stby_bypass` is set, standby moves to normal on the next edge and idle on the monitored lane is ignored. When the bit clears during idle, standby follows on the next edge.
- R10: With `hp_pd_inhibit` clear, outside power down `hp_out` equals `hp_det` as sampled on the previous edge.
- R11: The rules rank as follows: `pwr_en` low, then `force_pd`, then hot-plug loss, then `stby_bypass`, then the squelch-based rules.
- R12: `link_state` encodes power down as 0, standby as 1 and normal as 2; it never shows 3. Reset gives the R1 output condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Chip enable pin level |
| hp_det | input | 1 | Hot-plug detect level from the sink side |
| force_pd | input | 1 | Control bit: force power down |
| hp_pd_inhibit | input | 1 | Control bit: ignore hot-plug loss; hot-plug output driven high |
| stby_bypass | input | 1 | Control bit: skip standby while powered |
| frl_mode | input | 1 | 0: clock lane monitored; 1: data lane 2 monitored |
| sq_clk_active | input | 1 | Signal present on the clock lane |
| sq_d2_active | input | 1 | Signal present on data lane 2 |
| train_seen | input | 1 | One-cycle strobe: training pattern snooped |
| rx_lane_en | output | NUM_LANES | Receiver enable per lane; MSB is the clock lane |
| tx_drive_en | output | 1 | Transmitters driving (0 means high impedance) |
| ddc_en | output | 1 | Side-channel buffer active (0 means high impedance) |
| hp_out_oe | output | 1 | Hot-plug output driver enable |
| hp_out | output | 1 | Hot-plug output level |
| link_state | output | 2 | State code (0 down, 1 standby, 2 normal) |

## Verification
The bench builds the block with HP_LOSS_CYC=12, HP_GOOD_CYC=5, SQ_VALID_CYC=4 and SQ_IDLE_CYC=3. With these values every debounce window closes within a few cycles. Each window is probed on both sides of its limit: one cycle short of completion, then on the transition edge. This covers a hot-plug glitch one cycle shorter than the loss window and a signal-detect pulse one cycle shorter than the valid window. The short lengths also allow idle-return, snoop-exit and standby-bypass sequences to run in both lane-monitoring modes within one short run.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

   typedef enum logic [1:0] {
      LP_DOWN = 2'd0,
      LP_STBY = 2'd1,
      LP_NORM = 2'd2
   } lp_state_e;

endpackage

// File: rtl/link_pwr_dbnc.sv
// Saturating qualification counter: done rises once cond has been
// sampled true on LIMIT consecutive edges; any false sample or clr restarts it.
module link_pwr_dbnc #(
   parameter int CNT_W = 16,
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cond,
   output logic done
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
      $error("link_pwr_dbnc: CNT_W out of range");
   end
   if (LIMIT < 1 || LIMIT >= (1 << CNT_W)) begin : g_bad_limit
      $error("link_pwr_dbnc: LIMIT does not fit the counter");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || !cond)
         cnt_q <= '0;
      else if (cnt_q != LIM)
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LIM);

endmodule

// File: rtl/link_pwr_fsm.sv
// Next-state selection by priority plus the state register.
module link_pwr_fsm
   import link_pwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_en,
   input  logic      force_pd,
   input  logic      hp_pd_inhibit,
   input  logic      stby_bypass,
   input  logic      hp_lo_done,
   input  logic      hp_hi_done,
   input  logic      sig_ok,
   input  logic      idle_done,
   input  logic      train_seen,
   output lp_state_e state_q,
   output lp_state_e state_d
);
   logic hp_fault;
   logic exit_ok;

   assign hp_fault = !hp_pd_inhibit && hp_lo_done;
   assign exit_ok  = hp_pd_inhibit || hp_hi_done;

   always_comb begin
      state_d = state_q;
      if (!pwr_en || force_pd || hp_fault) begin
         state_d = LP_DOWN;
      end else begin
         unique case (state_q)
            LP_DOWN: if (exit_ok) state_d = stby_bypass ? LP_NORM : LP_STBY;
            LP_STBY: if (stby_bypass || train_seen || sig_ok) state_d = LP_NORM;
            LP_NORM: if (!stby_bypass && idle_done) state_d = LP_STBY;
            default: state_d = LP_DOWN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LP_DOWN;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/link_pwr_outreg.sv
// Registered pad-control decode, computed from the next state so that the
// controls move on the same edge as the state code.
module link_pwr_outreg
   import link_pwr_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int D2_LANE   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  lp_state_e            state_d,
   input  logic                 pwr_en,
   input  logic                 hp_det,
   input  logic                 hp_pd_inhibit,
   input  logic                 frl_mode,
   output logic [NUM_LANES-1:0] rx_lane_en,
   output logic                 tx_drive_en,
   output logic                 ddc_en,
   output logic                 hp_out_oe,
   output logic                 hp_out
);
   localparam int CLK_LANE = NUM_LANES - 1;

   logic [NUM_LANES-1:0] rx_d;
   logic                 live_d;

   assign live_d = pwr_en && (state_d != LP_DOWN);

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam bit IS_CLK = (i == CLK_LANE);
      localparam bit IS_D2  = (i == D2_LANE);
      assign rx_d[i] = (state_d == LP_NORM) ||
                       ((state_d == LP_STBY) && (frl_mode ? IS_D2 : IS_CLK));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lane_en  <= '0;
         tx_drive_en <= 1'b0;
         ddc_en      <= 1'b0;
         hp_out_oe   <= 1'b0;
         hp_out      <= 1'b0;
      end else begin
         rx_lane_en  <= live_d ? rx_d : '0;
         tx_drive_en <= live_d && (state_d == LP_NORM);
         ddc_en      <= pwr_en;
         hp_out_oe   <= pwr_en;
         hp_out      <= live_d && (hp_pd_inhibit || hp_det);
      end
   end

endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
   import link_pwr_pkg::*;
#(
   parameter int NUM_LANES    = 4,
   parameter int CNT_W        = 16,
   parameter int HP_LOSS_CYC  = 40000,
   parameter int HP_GOOD_CYC  = 20000,
   parameter int SQ_VALID_CYC = 1000,
   parameter int SQ_IDLE_CYC  = 2000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_en,
   input  logic                 hp_det,
   input  logic                 force_pd,
   input  logic                 hp_pd_inhibit,
   input  logic                 stby_bypass,
   input  logic                 frl_mode,
   input  logic                 sq_clk_active,
   input  logic                 sq_d2_active,
   input  logic                 train_seen,
   output logic [NUM_LANES-1:0] rx_lane_en,
   output logic                 tx_drive_en,
   output logic                 ddc_en,
   output logic                 hp_out_oe,
   output logic                 hp_out,
   output logic [1:0]           link_state
);
   localparam int D2_LANE = 2;

   if (NUM_LANES < D2_LANE + 2) begin : g_bad_lanes
      $error("link_pwr_ctrl: need a clock lane above data lane 2");
   end

   lp_state_e state_q, state_d;
   logic      sq_mon;
   logic      hp_lo_done, hp_hi_done, sig_ok, idle_done;

   assign sq_mon = frl_mode ? sq_d2_active : sq_clk_active;

   link_pwr_dbnc #(.CNT_W(CNT_W), .LIMIT(HP_LOSS_CYC)) u_hp_lo (
      .clk(clk), .rst_n(rst_n), .clr(!pwr_en), .cond(!hp_det), .done(hp_lo_done));

   link_pwr_dbnc #(.CNT_W(CNT_W), .LIMIT(HP_GOOD_CYC)) u_hp_hi (
      .clk(clk), .rst_n(rst_n), .clr(!pwr_en), .cond(hp_det), .done(hp_hi_done));

   link_pwr_dbnc #(.CNT_W(CNT_W), .LIMIT(SQ_VALID_CYC)) u_sig (
      .clk(clk), .rst_n(rst_n), .clr(state_q != LP_STBY), .cond(sq_mon), .done(sig_ok));

   link_pwr_dbnc #(.CNT_W(CNT_W), .LIMIT(SQ_IDLE_CYC)) u_idle (
      .clk(clk), .rst_n(rst_n), .clr(state_q != LP_NORM), .cond(!sq_mon), .done(idle_done));

   link_pwr_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .force_pd(force_pd),
      .hp_pd_inhibit(hp_pd_inhibit), .stby_bypass(stby_bypass),
      .hp_lo_done(hp_lo_done), .hp_hi_done(hp_hi_done), .sig_ok(sig_ok),
      .idle_done(idle_done), .train_seen(train_seen),
      .state_q(state_q), .state_d(state_d));

   link_pwr_outreg #(.NUM_LANES(NUM_LANES), .D2_LANE(D2_LANE)) u_out (
      .clk(clk), .rst_n(rst_n), .state_d(state_d), .pwr_en(pwr_en),
      .hp_det(hp_det), .hp_pd_inhibit(hp_pd_inhibit), .frl_mode(frl_mode),
      .rx_lane_en(rx_lane_en), .tx_drive_en(tx_drive_en), .ddc_en(ddc_en),
      .hp_out_oe(hp_out_oe), .hp_out(hp_out));

   assign link_state = state_q;

endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk #(
   parameter int NUM_LANES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pwr_en,
   input logic                 force_pd,
   input logic                 hp_pd_inhibit,
   input logic                 train_seen,
   input logic [NUM_LANES-1:0] rx_lane_en,
   input logic                 tx_drive_en,
   input logic                 ddc_en,
   input logic                 hp_out_oe,
   input logic                 hp_out,
   input logic [1:0]           link_state
);
   assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> (link_state == 2'd0 && rx_lane_en == '0 && !tx_drive_en &&
                   !ddc_en && !hp_out_oe && !hp_out));

   assert_forced_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && force_pd) |=> (link_state == 2'd0 && ddc_en && hp_out_oe && !hp_out &&
                                rx_lane_en == '0 && !tx_drive_en));

   assert_inhibit_holds_hp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && !force_pd && hp_pd_inhibit) |=> (hp_out && link_state != 2'd0));

   assert_standby_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 2'd1) |-> ($countones(rx_lane_en) == 1 && !tx_drive_en));

   assert_normal_all_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 2'd2) |-> (rx_lane_en == '1 && tx_drive_en));

   assert_snoop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && !force_pd && hp_pd_inhibit && link_state == 2'd1 && train_seen)
         |=> (link_state == 2'd2));

   assert_legal_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
      link_state != 2'd3);

endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .force_pd(force_pd),
   .hp_pd_inhibit(hp_pd_inhibit), .train_seen(train_seen),
   .rx_lane_en(rx_lane_en), .tx_drive_en(tx_drive_en), .ddc_en(ddc_en),
   .hp_out_oe(hp_out_oe), .hp_out(hp_out), .link_state(link_state));

// File: tb/link_pwr_ctrl_test.sv
`timescale 1ns/1ps
module link_pwr_ctrl_test;
   localparam int NL    = 4;
   localparam int LOSS  = 12;
   localparam int GOOD  = 5;
   localparam int VALID = 4;
   localparam int IDLE  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_en = 0, hp_det = 0, force_pd = 0, hp_pd_inhibit = 0, stby_bypass = 0;
   logic frl_mode = 0, sq_clk_active = 0, sq_d2_active = 0, train_seen = 0;
   logic [NL-1:0] rx_lane_en;
   logic tx_drive_en, ddc_en, hp_out_oe, hp_out;
   logic [1:0] link_state;

   always #4 clk = ~clk;

   link_pwr_ctrl #(
      .NUM_LANES(NL), .CNT_W(16), .HP_LOSS_CYC(LOSS), .HP_GOOD_CYC(GOOD),
      .SQ_VALID_CYC(VALID), .SQ_IDLE_CYC(IDLE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .hp_det(hp_det),
      .force_pd(force_pd), .hp_pd_inhibit(hp_pd_inhibit), .stby_bypass(stby_bypass),
      .frl_mode(frl_mode), .sq_clk_active(sq_clk_active), .sq_d2_active(sq_d2_active),
      .train_seen(train_seen), .rx_lane_en(rx_lane_en), .tx_drive_en(tx_drive_en),
      .ddc_en(ddc_en), .hp_out_oe(hp_out_oe), .hp_out(hp_out), .link_state(link_state));

   // observed vector: {state, rx[3:0], tx, ddc, hp_oe, hp_out}
   typedef struct {
      int         due;
      logic [9:0] vec;
      string      req;
   } exp_t;

   exp_t sb_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   finished = 1'b0;

   wire [9:0] obs = {link_state, rx_lane_en, tx_drive_en, ddc_en, hp_out_oe, hp_out};

   function automatic logic [9:0] mk(logic [1:0] st, logic [3:0] rx, logic tx,
                                     logic dd, logic oe, logic ho);
      return {st, rx, tx, dd, oe, ho};
   endfunction

   localparam logic [9:0] V_OFF = 10'b0;
   localparam logic [9:0] V_PD  = {2'd0, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0};

   function automatic logic [9:0] sbc(logic ho); return mk(2'd1, 4'b1000, 1'b0, 1'b1, 1'b1, ho); endfunction
   function automatic logic [9:0] sbd(logic ho); return mk(2'd1, 4'b0100, 1'b0, 1'b1, 1'b1, ho); endfunction
   function automatic logic [9:0] nm(logic ho);  return mk(2'd2, 4'b1111, 1'b1, 1'b1, 1'b1, ho); endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare scoreboard items as their edge count comes due
   always @(negedge clk) begin
      exp_t e;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         e = sb_q.pop_front();
         n_chk++;
         if (obs !== e.vec) begin
            n_err++;
            $display("FAIL %s: observed %b expected %b (edge %0d)", e.req, obs, e.vec, cyc);
         end
      end
   end

   task automatic expect_at(int k, logic [9:0] v, string r);
      exp_t e;
      e.due = cyc + k;
      e.vec = v;
      e.req = r;
      sb_q.push_back(e);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: observed hung run expected completion");
         finish_run();
      end
   end

   initial begin
      tick(3);
      n_chk++;
      if (obs !== V_OFF) begin
         n_err++;
         $display("FAIL R12 reset: observed %b expected %b", obs, V_OFF);
      end
      rst_n = 1'b1;
      expect_at(1, V_OFF, "R1 enable low after reset");
      tick(2);

      // R2: enabled, hot-plug low -> powered-down with side channel alive
      pwr_en = 1'b1;
      expect_at(1, V_PD, "R2 enabled power down");
      tick(1);

      // R4: hot-plug debounce to standby, legacy mode watches clock lane (R5)
      hp_det = 1'b1;
      expect_at(GOOD, V_PD, "R4 hot-plug window not yet met");
      expect_at(GOOD + 1, sbc(1'b1), "R4 standby on clock lane");
      tick(GOOD + 1);

      // R6: short detect pulse ignored
      sq_clk_active = 1'b1;
      tick(VALID - 1);
      sq_clk_active = 1'b0;
      expect_at(3, sbc(1'b1), "R6 short detect pulse ignored");
      tick(3);

      // R6: full debounce -> normal
      sq_clk_active = 1'b1;
      expect_at(VALID, sbc(1'b1), "R6 detect window not yet met");
      expect_at(VALID + 1, nm(1'b1), "R6 normal after valid signal");
      tick(VALID + 1);

      // R7: idle returns to standby
      sq_clk_active = 1'b0;
      expect_at(IDLE, nm(1'b1), "R7 idle window not yet met");
      expect_at(IDLE + 1, sbc(1'b1), "R7 back to standby on idle");
      tick(IDLE + 1);

      // R8: snoop strobe -> immediate normal, idle count restarts
      train_seen = 1'b1;
      expect_at(1, nm(1'b1), "R8 snoop exit");
      tick(1);
      train_seen = 1'b0;
      expect_at(IDLE, nm(1'b1), "R8 idle count fresh after snoop");
      expect_at(IDLE + 1, sbc(1'b1), "R8 idle after snoop");
      tick(IDLE + 1);

      // R5: FRL mode watches data lane 2; clock-lane detect ignored
      frl_mode = 1'b1;
      sq_clk_active = 1'b1;
      expect_at(1, sbd(1'b1), "R5 lane 2 monitored");
      expect_at(VALID + 3, sbd(1'b1), "R5 clock detect ignored in FRL");
      tick(VALID + 3);

      sq_d2_active = 1'b1;
      expect_at(VALID, sbd(1'b1), "R6 FRL window not yet met");
      expect_at(VALID + 1, nm(1'b1), "R6 FRL normal");
      tick(VALID + 1);

      sq_d2_active = 1'b0;
      expect_at(IDLE, nm(1'b1), "R7 FRL idle window not yet met");
      expect_at(IDLE + 1, sbd(1'b1), "R7 FRL idle with clock detect high");
      tick(IDLE + 1);

      // R9: standby bypass
      stby_bypass = 1'b1;
      expect_at(1, nm(1'b1), "R9 bypass to normal");
      expect_at(IDLE + 3, nm(1'b1), "R9 idle ignored while bypassed");
      tick(IDLE + 3);
      stby_bypass = 1'b0;
      expect_at(1, sbd(1'b1), "R9 bypass cleared");
      tick(1);

      // R10: hot-plug mirror and short glitch
      hp_det = 1'b0;
      expect_at(1, sbd(1'b0), "R10 hot-plug output follows low");
      tick(LOSS - 1);
      hp_det = 1'b1;
      expect_at(1, sbd(1'b1), "R10 hot-plug output follows high");
      expect_at(3, sbd(1'b1), "R2 short hot-plug loss ignored");
      tick(3);

      // R2: full hot-plug loss
      hp_det = 1'b0;
      expect_at(LOSS, sbd(1'b0), "R2 loss window not yet met");
      expect_at(LOSS + 1, V_PD, "R2 hot-plug loss power down");
      tick(LOSS + 1);

      hp_det = 1'b1;
      expect_at(GOOD, V_PD, "R4 reentry window not yet met");
      expect_at(GOOD + 1, sbd(1'b1), "R4 reentry to standby");
      tick(GOOD + 1);

      // R3: inhibit hot-plug power down
      hp_pd_inhibit = 1'b1;
      hp_det = 1'b0;
      expect_at(1, sbd(1'b1), "R3 output held high");
      expect_at(LOSS + 4, sbd(1'b1), "R3 long loss ignored");
      tick(LOSS + 4);

      // R2 / R4: forced power down and release with inhibit set
      force_pd = 1'b1;
      expect_at(1, V_PD, "R2 forced power down");
      tick(2);
      force_pd = 1'b0;
      expect_at(1, sbd(1'b1), "R4 release with inhibit");
      tick(1);

      // R11: forced down outranks bypass; enable low outranks all
      force_pd = 1'b1;
      stby_bypass = 1'b1;
      expect_at(1, V_PD, "R11 force beats bypass");
      tick(2);
      pwr_en = 1'b0;
      force_pd = 1'b0;
      hp_pd_inhibit = 1'b0;
      hp_det = 1'b1;
      expect_at(1, V_OFF, "R1 enable low");
      expect_at(3, V_OFF, "R11 enable low beats bypass");
      tick(3);

      // R9: re-enable with bypass goes straight to normal after hot-plug window
      pwr_en = 1'b1;
      expect_at(GOOD, V_PD, "R4 window restarts after enable");
      expect_at(GOOD + 1, nm(1'b1), "R9 straight to normal");
      tick(GOOD + 2);

      finished = 1'b1;
      if (sb_q.size() != 0) begin
         n_chk++;
         n_err++;
         $display("FAIL scoreboard: observed %0d pending expected 0", sb_q.size());
      end
      finish_run();
   end

endmodule